// File: doc/BRIEF.md
# I2C Target with Pin-Selected Address

This block is a target (slave) on a two-wire serial bus. It oversamples the clock line and the data line with the system clock. It finds start and stop conditions and the edges of the bus clock on the synchronised levels. It then follows the byte framing of the bus.

The 7-bit address the target answers to has two parts. The upper bits are fixed by a parameter. The lowest two bits come from board pins, so up to four identical targets can share one bus. When the address matches, the target acknowledges. It then does one of two things:

- It passes received bytes to a register-file port as one-cycle write strobes.
- It fetches bytes from that port and shifts them out onto the bus.

A byte pointer is cleared at every start condition and advances once per byte transferred. A read keeps going until the master withholds its acknowledge. Traffic for any other address is ignored until the next start condition.

The data line is open-drain. The output `sda_oe` high means "pull the line low". The surrounding pad turns this into the wired-AND bus line.

Top module: `i2c_tgt`

## Requirements
- R1: While and right after reset, `sda_oe` is 0, `wr_en` and `rd_en` are 0 and `reg_addr` is 0.
- R2: The target's own address is the 7-bit value {ADDR_HI, addr_sel}, with ADDR_HI in the upper five bits and addr_sel[1:0] in the lowest two. It arrives MSB first in the first seven bits after a start condition. When those seven bits equal the own address, the target holds `sda_oe` at 1 through the ninth clock pulse (acknowledge low).
- R3: When the address bits differ in any position, the target gives no acknowledge. It also raises no `wr_en` or `rd_en` and acknowledges no later byte until the next start condition.
- R4: When the eighth bit (direction) is 0, each following byte is received MSB first. Each byte appears on `wr_data` during a single-cycle `wr_en` pulse, and the target acknowledges each byte.
- R5: When the direction bit is 1, the target captures `rd_data` in the cycle of a single-cycle `rd_en` pulse. It then sends that byte MSB first. The first byte is captured after the address acknowledge, and each next byte after an acknowledge from the master.
- R6: When the master leaves the acknowledge bit high after a read byte, the target releases the data line. It sends nothing further (the master reads 0xFF) and raises no `rd_en` until the next start condition.
- R7: `reg_addr` is cleared to 0 by every start condition. It shows the pointer during each `wr_en`/`rd_en` pulse and advances by exactly one after each pulse. Otherwise it holds its value.
- R8: A start condition seen in any state (a repeated start included) restarts address reception. This holds even with no stop condition before it and after an ignored address.
- R9: A stop condition returns the target to idle and releases the data line. Bytes clocked after a stop but before a new start are ignored, even when they match the address.
- R10: `sda_oe` changes only while the synchronised bus clock is low, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 2 | Board pins giving the two lowest address bits |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | PTR_W | Byte pointer into the register file |
| wr_en | output | 1 | One-cycle strobe: write `wr_data` at `reg_addr` |
| wr_data | output | 8 | Received byte |
| rd_en | output | 1 | One-cycle strobe: `rd_data` at `reg_addr` is taken |
| rd_data | input | 8 | Register-file byte at `reg_addr` |

## Verification
Three things can fall in the same system-clock cycle: the byte strobe with its pointer step, and the change of the acknowledge drive. All of them come from one falling edge of the bus clock. The bench provokes this with back-to-back bytes in both directions. It judges the result in two ways:

- It logs `reg_addr` together with the data in each strobe cycle, and checks each logged address against the byte's position in the transaction.
- It watches `sda_oe` for any change while SCL is high.

Start conditions likewise land on a state that is in the middle of other work: after an acknowledge and after an ignored address. The bench checks that the pointer and address reception restart from zero.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned ADR_W  = 7;
  localparam int unsigned HI_W   = ADR_W - SEL_W;

  typedef enum logic [2:0] {
    ST_IDLE,   // ignoring the bus until a start condition
    ST_ADDR,   // shifting in address and direction
    ST_AACK,   // driving the address acknowledge
    ST_RX,     // shifting in a write byte
    ST_WACK,   // driving the data acknowledge
    ST_TX,     // shifting out a read byte
    ST_RACK    // sampling the master acknowledge
  } tgt_state_e;

  typedef struct packed {
    logic scl_lvl;
    logic scl_rise;
    logic scl_fall;
    logic sda_lvl;
    logic start_c;
    logic stop_c;
  } bus_evt_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);
  localparam int unsigned LINES = 2;
  localparam int unsigned IDX_SCL = 0;
  localparam int unsigned IDX_SDA = 1;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] prv_q;

  assign raw = {sda_i, scl_i};

  // One synchroniser chain per bus line; idle bus level is high.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;
    if (STAGES > 1) begin : g_multi
      assign pipe_d = {pipe_q[STAGES-2:0], raw[g]};
    end else begin : g_single
      assign pipe_d = raw[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= pipe_d;
    end
    assign lvl[g] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_q <= '1;
    else        prv_q <= lvl;
  end

  always_comb begin
    evt.scl_lvl  = lvl[IDX_SCL];
    evt.sda_lvl  = lvl[IDX_SDA];
    evt.scl_rise = lvl[IDX_SCL] & ~prv_q[IDX_SCL];
    evt.scl_fall = ~lvl[IDX_SCL] & prv_q[IDX_SCL];
    evt.start_c  = lvl[IDX_SCL] & prv_q[IDX_SCL] & prv_q[IDX_SDA] & ~lvl[IDX_SDA];
    evt.stop_c   = lvl[IDX_SCL] & prv_q[IDX_SCL] & ~prv_q[IDX_SDA] & lvl[IDX_SDA];
  end
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  assign ptr_en = clr | step;

  always_comb begin
    if (clr) ptr_d = '0;
    else     ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [HI_W-1:0] ADDR_HI = 5'b10100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              rd_stb
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  tgt_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              oe_q, oe_d;
  logic              nack_q, nack_d;
  logic              byte_full;
  logic [ADR_W-1:0]  own_addr;

  assign own_addr  = {ADDR_HI, addr_sel};
  assign byte_full = (cnt_q == CNT_FULL);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    nack_d  = nack_q;
    wr_stb  = 1'b0;
    rd_stb  = 1'b0;
    if (evt.start_c) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (evt.stop_c) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (evt.scl_rise && !byte_full) begin
            sh_d  = {sh_q[BYTE_W-2:0], evt.sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end
          if (evt.scl_fall && byte_full) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == own_addr) begin
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
                state_d = ST_AACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              wr_stb  = 1'b1;
              oe_d    = 1'b1;
              state_d = ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (evt.scl_fall) begin
            if (rw_q) begin
              rd_stb  = 1'b1;
              sh_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_RX;
            end
          end
        end
        ST_WACK: begin
          if (evt.scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_RX;
          end
        end
        ST_TX: begin
          if (evt.scl_rise && !byte_full) cnt_d = cnt_q + 1'b1;
          if (evt.scl_fall) begin
            if (byte_full) begin
              oe_d    = 1'b0;
              state_d = ST_RACK;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (evt.scl_rise) nack_d = evt.sda_lvl;
          if (evt.scl_fall) begin
            if (!nack_q) begin
              rd_stb  = 1'b1;
              sh_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_TX;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      nack_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
      nack_q  <= nack_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_byte = sh_q;
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter logic [4:0]  ADDR_HI = 5'b10100,
  parameter int unsigned PTR_W   = 8,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [1:0]       addr_sel,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             rd_en,
  input  logic [7:0]       rd_data
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  bus_evt_t   evt;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  i2c_tgt_sync #(.STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt   (evt)
  );

  i2c_tgt_ctrl #(.ADDR_HI(ADDR_HI)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .evt      (evt),
    .addr_sel (addr_sel),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_en),
    .wr_byte  (wr_data),
    .rd_stb   (rd_en)
  );

  i2c_tgt_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (evt.start_c),
    .step  (wr_en | rd_en),
    .ptr   (reg_addr)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input bus_evt_t         evt,
  input logic             sda_oe,
  input logic [PTR_W-1:0] reg_addr,
  input logic             wr_en,
  input logic             rd_en
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R4

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R4

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en); // R5

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1))); // R7

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en && !evt.start_c) |=> $stable(reg_addr)); // R7

  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start_c |=> (reg_addr == '0)); // R8

  AST_STOP_REL: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stop_c |=> !sda_oe); // R9

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(evt.scl_lvl)); // R10
endmodule

bind i2c_tgt i2c_tgt_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt      (evt),
  .sda_oe   (sda_oe),
  .reg_addr (reg_addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en)
);

// File: tb/sim_i2c_tgt.sv
module sim_i2c_tgt;
  localparam int PTR_W = 8;
  localparam logic [4:0] HI = 5'b10100;
  localparam int Q = 10;

  logic clk;
  logic rst_n;
  logic scl_m;
  logic sda_m;
  logic sda_bus;
  logic [1:0] addr_sel;
  logic sda_oe;
  logic [PTR_W-1:0] reg_addr;
  logic wr_en;
  logic [7:0] wr_data;
  logic rd_en;
  logic [7:0] rd_data;
  logic [7:0] key;

  int total;
  int fails;
  bit done;
  int wcnt;
  int rcnt;
  int viol;
  logic [PTR_W-1:0] wl_a [0:63];
  logic [7:0]       wl_d [0:63];
  logic [PTR_W-1:0] rl_a [0:63];
  logic scl_prev;
  logic oe_prev;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  function automatic logic [7:0] pat(input logic [PTR_W-1:0] a, input logic [7:0] k);
    return 8'(a * 29 + 7) ^ k;
  endfunction

  assign rd_data = pat(reg_addr, key);

  i2c_tgt #(.ADDR_HI(HI), .PTR_W(PTR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
  );

  // Strobe logs and the SDA-while-SCL-high monitor, sampled away from the edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      oe_prev  <= 1'b0;
    end else begin
      if (wr_en) begin
        wl_a[wcnt[5:0]] <= reg_addr;
        wl_d[wcnt[5:0]] <= wr_data;
        wcnt <= wcnt + 1;
      end
      if (rd_en) begin
        rl_a[rcnt[5:0]] <= reg_addr;
        rcnt <= rcnt + 1;
      end
      if (scl_m && scl_prev && (sda_oe != oe_prev)) viol <= viol + 1;
      scl_prev <= scl_m;
      oe_prev  <= sda_oe;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q);
      scl_m = 1'b1; wt(Q);
      scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q / 2);
    acked = ~sda_bus;
    wt(Q / 2);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q);
      scl_m = 1'b1; wt(Q / 2);
      b[i] = sda_bus;
      wt(Q / 2);
      scl_m = 1'b0;
    end
    wt(Q);
    sda_m = mack ? 1'b0 : 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    scl_m = 1'b0; wt(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    int w0;
    int r0;
    total = 0; fails = 0; done = 0;
    wcnt = 0; rcnt = 0; viol = 0;
    scl_m = 1'b1; sda_m = 1'b1; addr_sel = 2'd0; key = 8'h00;
    rst_n = 1'b0;
    wt(5);
    chk(sda_oe == 1'b0 && wr_en == 1'b0 && rd_en == 1'b0, "R1 outputs in reset", sda_oe, 0);
    rst_n = 1'b1;
    wt(5);
    chk(sda_oe == 1'b0 && reg_addr == '0 && !wr_en && !rd_en, "R1 after reset", reg_addr, 0);

    // R2/R3/R4/R7: all pin settings against all low-bit choices.
    for (int sel = 0; sel < 4; sel++) begin
      addr_sel = 2'(sel);
      wt(4);
      for (int lo = 0; lo < 4; lo++) begin
        w0 = wcnt;
        bus_start();
        wr_byte({HI, 2'(lo), 1'b0}, ack);
        if (lo == sel) begin
          chk(ack == 1'b1, "R2 address acknowledged", ack, 1);
          wr_byte(8'(sel * 64 + lo * 16 + 3), ack);
          chk(ack == 1'b1, "R4 first data byte acked", ack, 1);
          wr_byte(8'(~(sel * 17 + lo)), ack);
          chk(ack == 1'b1, "R4 second data byte acked", ack, 1);
          chk(wcnt - w0 == 2, "R4 write strobe count", wcnt - w0, 2);
          chk(wl_d[w0[5:0]] == 8'(sel * 64 + lo * 16 + 3), "R4 first byte data",
              wl_d[w0[5:0]], sel * 64 + lo * 16 + 3);
          chk(wl_d[6'(w0 + 1)] == 8'(~(sel * 17 + lo)), "R4 second byte data",
              wl_d[6'(w0 + 1)], 8'(~(sel * 17 + lo)));
          chk(wl_a[w0[5:0]] == 0 && wl_a[6'(w0 + 1)] == 1, "R7 write pointer sequence",
              wl_a[6'(w0 + 1)], 1);
        end else begin
          chk(ack == 1'b0, "R3 foreign low bits not acked", ack, 0);
          wr_byte(8'h5A, ack);
          chk(ack == 1'b0 && wcnt == w0, "R3 foreign data ignored", wcnt - w0, 0);
        end
        bus_stop();
        chk(sda_oe == 1'b0, "R9 line released after stop", sda_oe, 0);
      end
    end

    // R3: mismatch in each fixed upper bit.
    addr_sel = 2'd2;
    for (int bit_i = 0; bit_i < 5; bit_i++) begin
      w0 = wcnt; r0 = rcnt;
      bus_start();
      wr_byte({HI ^ 5'(1 << bit_i), 2'd2, 1'b1}, ack);
      chk(ack == 1'b0, "R3 upper bit mismatch not acked", ack, 0);
      wr_byte(8'h00, ack);
      chk(ack == 1'b0 && wcnt == w0 && rcnt == r0, "R3 no strobes after mismatch",
          wcnt - w0 + rcnt - r0, 0);
      bus_stop();
    end

    // R5/R6/R7: reads with two data patterns and two lengths.
    for (int pass = 0; pass < 2; pass++) begin
      int len;
      len = (pass == 0) ? 3 : 5;
      key = (pass == 0) ? 8'h00 : 8'hA5;
      r0 = rcnt;
      bus_start();
      wr_byte({HI, 2'd2, 1'b1}, ack);
      chk(ack == 1'b1, "R2 read address acknowledged", ack, 1);
      for (int k = 0; k < len; k++) begin
        rd_byte(k != len - 1, b);
        chk(b == pat(PTR_W'(k), key), "R5 read byte value", b, pat(PTR_W'(k), key));
        chk(rl_a[6'(r0 + k)] == PTR_W'(k), "R7 read pointer", rl_a[6'(r0 + k)], k);
      end
      chk(rcnt - r0 == len, "R5 read strobe count", rcnt - r0, len);
      chk(sda_oe == 1'b0, "R6 line released after nack", sda_oe, 0);
      rd_byte(1'b1, b);
      chk(b == 8'hFF && rcnt - r0 == len, "R6 nothing sent after nack", b, 8'hFF);
      bus_stop();
    end

    // R8: repeated start after a write, then read from a cleared pointer.
    key = 8'h3C;
    r0 = rcnt; w0 = wcnt;
    bus_start();
    wr_byte({HI, 2'd2, 1'b0}, ack);
    wr_byte(8'h81, ack);
    chk(wcnt - w0 == 1 && wl_a[w0[5:0]] == 0, "R8 write before repeated start", wcnt - w0, 1);
    bus_start();
    wr_byte({HI, 2'd2, 1'b1}, ack);
    chk(ack == 1'b1, "R8 address after repeated start", ack, 1);
    rd_byte(1'b0, b);
    chk(b == pat('0, key) && rl_a[r0[5:0]] == 0, "R8 pointer cleared by start", b, pat('0, key));
    // R8: repeated start after an ignored address.
    bus_start();
    wr_byte({HI, 2'd1, 1'b0}, ack);
    chk(ack == 1'b0, "R8 ignored address first", ack, 0);
    bus_start();
    wr_byte({HI, 2'd2, 1'b0}, ack);
    chk(ack == 1'b1, "R8 start recovers from ignore", ack, 1);
    bus_stop();

    // R9: matching bytes after a stop without a new start.
    w0 = wcnt; r0 = rcnt;
    scl_m = 1'b0; wt(Q);
    wr_byte({HI, 2'd2, 1'b0}, ack);
    chk(ack == 1'b0, "R9 match after stop ignored", ack, 0);
    wr_byte(8'h11, ack);
    chk(ack == 1'b0 && wcnt == w0 && rcnt == r0, "R9 no strobes after stop", wcnt - w0, 0);
    bus_stop();

    chk(viol == 0, "R10 sda_oe change while SCL high", viol, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule